// File: doc/BRIEF.md
# Fault-injectable memory array model

A small word-addressed memory built from flip-flops, meant to sit under built-in self-test logic as a test target. With no fault armed it is an ideal single-port RAM: a write stores a word, and a read returns the stored word one cycle later. A configuration port can arm exactly one misbehaviour at a time. One bit cell, the victim, can be made stuck, unable to make one transition, or leaky. It can also be made to react to a second cell, the aggressor, through inversion, idempotent or state coupling. Instead of a cell fault, the decoder can be made to mis-select one address, the aggressor address.

The configuration fields are the fault kind, the aggressor word and bit, the victim word and bit, a fault value (`cfg_pol`), a trigger value (`cfg_trig`) and a leak time in cycles. The block captures them only in a cycle where `cfg_en` is high, and they take effect in the next cycle. Fault kind encodings are: 0 none, 1 stuck, 2 transition, 3 inversion coupling, 4 idempotent coupling, 5 state coupling, 6 decoder wrong word, 7 decoder multiple words, 8 decoder no word, 9 retention. Codes 10 to 15 are taken as 0.

Two state machines drive the block. The mode machine has the states MODE_IDEAL and MODE_FAULTY. In a configuration cycle it goes to MODE_FAULTY when the captured kind is non-zero, and to MODE_IDEAL when it is zero. In every other cycle it holds its state. The retention machine has the states RT_IDLE, RT_COUNT and RT_DECAYED. A write to the victim word under kind 9 moves it to RT_COUNT with the count at zero. While in RT_COUNT it counts cycles, and when the count reaches the leak time it moves to RT_DECAYED and the victim bit takes the fault value. A later write to the victim word restarts it in RT_COUNT. A configuration cycle, or leaving kind 9, returns it to RT_IDLE.

Top module: `fault_mem`

## Requirements
- R1: With kind 0, a read (`we`=0) of address A loads `rdata` at the clock edge with the last word written to A. In a write cycle `rdata` keeps its previous value.
- R2: With kind 1, a read of the victim word returns the victim bit equal to `cfg_pol` whatever was written. The other bits read as written.
- R3: With kind 2, a write that would move the victim bit from the inverse of `cfg_pol` to `cfg_pol` leaves the bit unchanged. A write in the other direction succeeds.
- R4: With kind 3, a write to the aggressor word that changes the aggressor bit, in either direction, inverts the stored victim bit.
- R5: With kind 4, a write that changes the aggressor bit to the value `cfg_trig` sets the stored victim bit to `cfg_pol`. An aggressor change in the other direction has no effect on the victim.
- R6: With kind 5, while the stored aggressor bit equals `cfg_trig`, reads of the victim word return the victim bit as `cfg_pol`. Otherwise the victim bit reads as stored.
- R7: With kind 6, writes to the aggressor address land in the victim word and leave the aggressor word untouched. Reads of the aggressor address return the victim word.
- R8: With kind 7, a write to the aggressor address stores the data in both the aggressor word and the victim word. A read of the aggressor address returns the bitwise AND of the two words.
- R9: With kind 8, writes to the aggressor address are dropped and reads of it return all zeros.
- R10: With kind 9, the victim bit reads back as written soon after a write. Once `cfg_ret` + 1 clock edges pass after the last write to the victim word, the bit becomes `cfg_pol`. Reads do not restart the count; writes do.
- R11: After reset every word reads zero and `rdata` is zero. Configuration inputs changed while `cfg_en` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| cfg_en | input | 1 | Capture the configuration fields this cycle |
| cfg_kind | input | 4 | Fault kind code |
| cfg_agg_addr | input | ADDR_W | Aggressor word (also the mis-decoded address) |
| cfg_agg_bit | input | log2(DATA_W) | Aggressor bit |
| cfg_vic_addr | input | ADDR_W | Victim word |
| cfg_vic_bit | input | log2(DATA_W) | Victim bit |
| cfg_pol | input | 1 | Fault value |
| cfg_trig | input | 1 | Aggressor trigger value |
| cfg_ret | input | RET_W | Leak time in cycles |

## Verification
The hardest case to reach is the coupling fault. The victim only misbehaves when the same write hits the aggressor word and also flips the aggressor bit, in the right direction for idempotent coupling, and that effect then has to be seen through a later read of a different word. The random phases therefore place a fresh aggressor and victim in distinct words for each fault kind. They aim about half of all accesses at those two words with random data, so toggles in both directions happen many times. The leak is reached with directed idle gaps that sit well clear of the leak time on both sides. One of these gaps contains a read, to show that reads do not restart the count.

// File: rtl/fault_mem_pkg.sv
package fault_mem_pkg;

    typedef enum logic [3:0] {
        FK_NONE      = 4'd0,
        FK_STUCK     = 4'd1,
        FK_TRANS     = 4'd2,
        FK_INV       = 4'd3,
        FK_IDEM      = 4'd4,
        FK_STATE     = 4'd5,
        FK_DEC_WRONG = 4'd6,
        FK_DEC_MULTI = 4'd7,
        FK_DEC_NONE  = 4'd8,
        FK_RETAIN    = 4'd9
    } fault_kind_e;

    typedef enum logic {
        MODE_IDEAL  = 1'b0,
        MODE_FAULTY = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        RT_IDLE    = 2'd0,
        RT_COUNT   = 2'd1,
        RT_DECAYED = 2'd2
    } rt_state_e;

endpackage

// File: rtl/fault_mem_cfg.sv
module fault_mem_cfg
    import fault_mem_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BIT_W  = 3,
    parameter int RET_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [3:0]        cfg_kind,
    input  logic [ADDR_W-1:0] cfg_agg_addr,
    input  logic [BIT_W-1:0]  cfg_agg_bit,
    input  logic [ADDR_W-1:0] cfg_vic_addr,
    input  logic [BIT_W-1:0]  cfg_vic_bit,
    input  logic              cfg_pol,
    input  logic              cfg_trig,
    input  logic [RET_W-1:0]  cfg_ret,
    output fault_kind_e       kind,
    output logic [ADDR_W-1:0] agg_a,
    output logic [BIT_W-1:0]  agg_b,
    output logic [ADDR_W-1:0] vic_a,
    output logic [BIT_W-1:0]  vic_b,
    output logic              pol,
    output logic              trig,
    output logic [RET_W-1:0]  ret_lim
);

    mode_e       mode_q, mode_d;
    fault_kind_e kind_q, kind_d;

    always_comb begin
        if (cfg_kind > 4'd9) kind_d = FK_NONE;
        else                 kind_d = fault_kind_e'(cfg_kind);
    end

    always_comb begin
        mode_d = mode_q;
        if (cfg_en) begin
            unique case (kind_d)
                FK_NONE: mode_d = MODE_IDEAL;
                default: mode_d = MODE_FAULTY;
            endcase
        end
    end

    // State register and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_IDEAL;
            kind_q  <= FK_NONE;
            agg_a   <= '0;
            agg_b   <= '0;
            vic_a   <= '0;
            vic_b   <= '0;
            pol     <= 1'b0;
            trig    <= 1'b0;
            ret_lim <= '0;
        end else begin
            mode_q <= mode_d;
            if (cfg_en) begin
                kind_q  <= kind_d;
                agg_a   <= cfg_agg_addr;
                agg_b   <= cfg_agg_bit;
                vic_a   <= cfg_vic_addr;
                vic_b   <= cfg_vic_bit;
                pol     <= cfg_pol;
                trig    <= cfg_trig;
                ret_lim <= cfg_ret;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (mode_q)
            MODE_FAULTY: kind = kind_q;
            default:     kind = FK_NONE;
        endcase
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> ($stable(kind) && $stable(agg_a) && $stable(vic_a)
                     && $stable(agg_b) && $stable(vic_b) && $stable(pol)
                     && $stable(trig) && $stable(ret_lim))); // R11

endmodule

// File: rtl/fault_mem_retention.sv
module fault_mem_retention
    import fault_mem_pkg::*;
#(
    parameter int RET_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             clear,
    input  logic             restart,
    input  logic [RET_W-1:0] limit,
    output logic             leak
);

    rt_state_e        st_q, st_d;
    logic [RET_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (clear || !arm) begin
            st_d  = RT_IDLE;
            cnt_d = '0;
        end else if (restart) begin
            st_d  = RT_COUNT;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                RT_IDLE:    st_d = RT_IDLE;
                RT_COUNT: begin
                    if (cnt_q == limit) st_d = RT_DECAYED;
                    else                cnt_d = cnt_q + RET_W'(1);
                end
                RT_DECAYED: st_d = RT_DECAYED;
                default:    st_d = RT_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RT_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        leak = 1'b0;
        unique case (st_q)
            RT_COUNT: leak = (st_d == RT_DECAYED);
            default:  leak = 1'b0;
        endcase
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RT_COUNT) |-> (cnt_q <= limit)); // R10

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && arm && !clear) |=> (st_q == RT_COUNT && cnt_q == '0)); // R10

endmodule

// File: rtl/fault_mem.sv
module fault_mem
    import fault_mem_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int RET_W  = 12,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cfg_en,
    input  logic [3:0]        cfg_kind,
    input  logic [ADDR_W-1:0] cfg_agg_addr,
    input  logic [BIT_W-1:0]  cfg_agg_bit,
    input  logic [ADDR_W-1:0] cfg_vic_addr,
    input  logic [BIT_W-1:0]  cfg_vic_bit,
    input  logic              cfg_pol,
    input  logic              cfg_trig,
    input  logic [RET_W-1:0]  cfg_ret
);

    fault_kind_e       kind;
    logic [ADDR_W-1:0] agg_a, vic_a;
    logic [BIT_W-1:0]  agg_b, vic_b;
    logic              pol, trig, leak;
    logic [RET_W-1:0]  ret_lim;

    logic [DATA_W-1:0] mem   [DEPTH];
    logic [DATA_W-1:0] mem_n [DEPTH];
    logic [DATA_W-1:0] rd_val;
    logic              agg_old, agg_new, agg_tog;

    fault_mem_cfg #(.ADDR_W(ADDR_W), .BIT_W(BIT_W), .RET_W(RET_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_kind(cfg_kind),
        .cfg_agg_addr(cfg_agg_addr), .cfg_agg_bit(cfg_agg_bit),
        .cfg_vic_addr(cfg_vic_addr), .cfg_vic_bit(cfg_vic_bit),
        .cfg_pol(cfg_pol), .cfg_trig(cfg_trig), .cfg_ret(cfg_ret),
        .kind(kind), .agg_a(agg_a), .agg_b(agg_b), .vic_a(vic_a),
        .vic_b(vic_b), .pol(pol), .trig(trig), .ret_lim(ret_lim)
    );

    fault_mem_retention #(.RET_W(RET_W)) u_ret (
        .clk(clk), .rst_n(rst_n),
        .arm(kind == FK_RETAIN),
        .clear(cfg_en),
        .restart(we && (addr == vic_a)),
        .limit(ret_lim),
        .leak(leak)
    );

    // Next array contents: decoder faults, cell faults, coupling, leak
    always_comb begin
        mem_n   = mem;
        agg_old = mem[agg_a][agg_b];
        agg_new = wdata[agg_b];
        agg_tog = we && (addr == agg_a) && (agg_old != agg_new);
        if (we) begin
            if (kind == FK_DEC_WRONG && addr == agg_a) begin
                mem_n[vic_a] = wdata;
            end else if (!(kind == FK_DEC_NONE && addr == agg_a)) begin
                mem_n[addr] = wdata;
                if (kind == FK_DEC_MULTI && addr == agg_a)
                    mem_n[vic_a] = wdata;
                if (kind == FK_TRANS && addr == vic_a &&
                    mem[vic_a][vic_b] != pol && wdata[vic_b] == pol)
                    mem_n[vic_a][vic_b] = mem[vic_a][vic_b];
            end
            if (kind == FK_INV && agg_tog)
                mem_n[vic_a][vic_b] = ~mem_n[vic_a][vic_b];
            if (kind == FK_IDEM && agg_tog && agg_new == trig)
                mem_n[vic_a][vic_b] = pol;
        end
        if (leak)
            mem_n[vic_a][vic_b] = pol;
    end

    // Read path with decoder and read-side cell faults
    always_comb begin
        rd_val = mem[addr];
        unique case (kind)
            FK_DEC_WRONG: if (addr == agg_a) rd_val = mem[vic_a];
            FK_DEC_MULTI: if (addr == agg_a) rd_val = mem[agg_a] & mem[vic_a];
            FK_DEC_NONE:  if (addr == agg_a) rd_val = '0;
            FK_STUCK:     if (addr == vic_a) rd_val[vic_b] = pol;
            FK_STATE:     if (addr == vic_a && mem[agg_a][agg_b] == trig)
                              rd_val[vic_b] = pol;
            default:      rd_val = mem[addr];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem   <= '{default: '0};
            rdata <= '0;
        end else begin
            mem <= mem_n;
            if (!we) rdata <= rd_val;
        end
    end

    AST_WRITE_HOLDS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> $stable(rdata)); // R1

    AST_STUCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !cfg_en && kind == FK_STUCK && addr == vic_a)
        |=> (rdata[vic_b] == pol)); // R2

    AST_NO_CELL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && kind == FK_DEC_NONE && addr == agg_a) |=> (rdata == '0)); // R9

endmodule

// File: tb/sim_fault_mem.sv
module sim_fault_mem;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cfg_en = 1'b0;
    logic [3:0] cfg_kind = '0;
    logic [3:0] cfg_agg_addr = '0, cfg_vic_addr = '0;
    logic [2:0] cfg_agg_bit = '0, cfg_vic_bit = '0;
    logic       cfg_pol = 1'b0, cfg_trig = 1'b0;
    logic [11:0] cfg_ret = '0;

    int tests = 0;
    int fails = 0;

    // bench model of the configuration and the array
    int         k = 0;
    logic [3:0] aa = 0, va = 0;
    logic [2:0] ab = 0, vb = 0;
    logic       pl = 0, tg = 0;
    logic [7:0] rm [16];

    string tag_of [10] = '{"R1","R2","R3","R4","R5","R6","R7","R8","R9","R10"};

    always #4 clk = ~clk;

    fault_mem u0 (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cfg_en(cfg_en), .cfg_kind(cfg_kind),
        .cfg_agg_addr(cfg_agg_addr), .cfg_agg_bit(cfg_agg_bit),
        .cfg_vic_addr(cfg_vic_addr), .cfg_vic_bit(cfg_vic_bit),
        .cfg_pol(cfg_pol), .cfg_trig(cfg_trig), .cfg_ret(cfg_ret)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rdata actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        logic [7:0] v;
        v = rm[a];
        if (k == 6 && a == aa) v = rm[va];
        if (k == 7 && a == aa) v = rm[aa] & rm[va];
        if (k == 8 && a == aa) v = 8'h00;
        if (a == va && k == 1) v[vb] = pl;
        if (a == va && k == 5 && rm[aa][ab] == tg) v[vb] = pl;
        return v;
    endfunction

    task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
        logic tgl;
        logic ov;
        tgl = (a == aa) && (rm[aa][ab] != d[ab]);
        ov  = rm[va][vb];
        if (k == 6 && a == aa) rm[va] = d;
        else if (!(k == 8 && a == aa)) begin
            rm[a] = d;
            if (k == 7 && a == aa) rm[va] = d;
            if (k == 2 && a == va && ov != pl && d[vb] == pl) rm[va][vb] = ov;
        end
        if (k == 3 && tgl) rm[va][vb] = ~rm[va][vb];
        if (k == 4 && tgl && d[ab] == tg) rm[va][vb] = pl;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        model_wr(a, d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        we = 1'b0; addr = a;
        e = exp_rd(a);
        @(negedge clk);
        check(tag, rdata, e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic configure(input int kk, input logic [3:0] a1, input logic [2:0] b1,
                             input logic [3:0] a2, input logic [2:0] b2,
                             input logic p, input logic t, input logic [11:0] lim);
        @(negedge clk);
        we = 1'b0;
        cfg_kind = 4'(kk); cfg_agg_addr = a1; cfg_agg_bit = b1;
        cfg_vic_addr = a2; cfg_vic_bit = b2; cfg_pol = p; cfg_trig = t; cfg_ret = lim;
        cfg_en = 1'b1;
        k = kk; aa = a1; ab = b1; va = a2; vb = b2; pl = p; tg = t;
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    function automatic logic [3:0] pick_addr();
        int r;
        r = int'($urandom % 4);
        if (r == 0) return aa;
        if (r == 1) return va;
        return 4'($urandom % 16);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) rm[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset rdata", rdata, 8'h00);
        for (int i = 0; i < 16; i++) rd(4'(i), "R11 reset word");

        // directed ideal behaviour and read hold during writes
        wr(4'd3, 8'h5A);
        rd(4'd3, "R1");
        @(negedge clk);
        we = 1'b1; addr = 4'd4; wdata = 8'hC3; model_wr(4'd4, 8'hC3);
        @(negedge clk);
        we = 1'b0;
        check("R1 hold in write", rdata, 8'h5A);
        rd(4'd4, "R1");

        // configuration lines moved with cfg_en low do nothing
        @(negedge clk);
        cfg_kind = 4'd8; cfg_agg_addr = 4'd3;
        idle(2);
        rd(4'd3, "R11 cfg ignored");

        // directed inversion coupling toggles in both directions
        configure(3, 4'd5, 3'd0, 4'd6, 3'd2, 1'b0, 1'b0, 12'd0);
        wr(4'd6, 8'h00);
        wr(4'd5, 8'h01);
        rd(4'd6, "R4");
        wr(4'd5, 8'h00);
        rd(4'd6, "R4");

        // directed idempotent coupling: only the trigger direction acts
        configure(4, 4'd5, 3'd0, 4'd6, 3'd2, 1'b1, 1'b0, 12'd0);
        wr(4'd6, 8'h00);
        wr(4'd5, 8'h01);
        rd(4'd6, "R5");
        wr(4'd5, 8'h00);
        rd(4'd6, "R5");

        // random phases, one per fault kind
        for (int kk = 0; kk < 9; kk++) begin
            logic [3:0] a1, a2;
            a1 = 4'($urandom % 16);
            a2 = 4'((32'(a1) + 1 + ($urandom % 15)) % 16);
            configure(kk, a1, 3'($urandom % 8), a2, 3'($urandom % 8),
                      1'($urandom % 2), 1'($urandom % 2), 12'd0);
            for (int n = 0; n < 60; n++) begin
                if ($urandom % 2 == 0) wr(pick_addr(), 8'($urandom));
                else rd(pick_addr(), tag_of[kk]);
            end
        end

        // retention: immediate read passes, leak after the limit, restart on write
        configure(9, 4'd0, 3'd0, 4'd9, 3'd3, 1'b0, 1'b0, 12'd20);
        wr(4'd9, 8'hFF);
        rd(4'd9, "R10 immediate");
        idle(30);
        rm[9][3] = 1'b0;
        rd(4'd9, "R10 leaked");
        wr(4'd9, 8'hFF);
        idle(8);
        rd(4'd9, "R10 restarted");
        idle(15);
        rm[9][3] = 1'b0;
        rd(4'd9, "R10 read does not restart");

        // back to ideal
        configure(0, 4'd0, 3'd0, 4'd0, 3'd0, 1'b0, 1'b0, 12'd0);
        wr(4'd9, 8'hA5);
        rd(4'd9, "R1");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule